// File: doc/BRIEF.md
# Serial Flash Transfer Controller

This block is a register-programmed SPI master for a serial data flash. Software loads up to five command bytes and a data length. It also sets the command byte count, a data-phase enable, a direction bit and a clock divider. A write to the control register then starts a transfer. A three-state sequencer (idle, command, data) first clocks the stored command bytes out on MOSI. It then optionally streams data bytes: either to the flash from a transmit stream, or from the flash onto a receive stream. It then returns to idle.

The two data streams use valid/ready handshakes. A byte moves on a clock edge where valid and ready are both high. In a write data phase the controller raises `tx_ready` only when its shifter is free. If `tx_valid` is low, SCK stays low and the transfer pauses. In a read data phase each received byte is held on `rx_data` with `rx_valid` high until `rx_ready` is seen. The next byte is not clocked in before then. A byte counter and two sticky interrupt flags report progress. The flags are a finish flag and a mid-transfer flag set at a programmable multiple of 16 bytes.

Register map (8-bit data, 4-bit address):
- 0: bit 7 enable, bits 6:0 divider D.
- 1: control. Bit 4 data enable, bit 3 read, bits 2:0 command count.
- 2: interrupt. Bits 7:4 mid count M, bit 1 mid flag, bit 0 finish flag.
- 3: data length.
- 4: byte counter (read only).
- 5 to 9: command bytes 0 to 4.

Top module: `sflash_xfer_ctrl`

## Requirements
- R1: After reset:
  - `spi_cs_n` is 1, and `spi_sck`, `busy`, `irq_fin` and `irq_mid` are 0.
  - Every register at addresses 0 to 9 reads 0.
- R2: A transfer starts only on a write to address 1 while idle, with the enable bit (address 0 bit 7) set and D not 0.
  - A control write with enable 0 stores the fields but starts nothing.
  - A control write with D equal to 0 stores the fields but starts nothing.
  - A started transfer sends the command bytes from address 5 upward, MSB first.
- R3: SPI mode 0 is used. SCK rises every D+1 clock cycles within a byte.
  - SCK stays high for D - floor(D/2) cycles per bit.
  - MOSI changes only while SCK is low.
  - MISO is sampled on the rising edge of SCK.
- R4: `spi_cs_n` is low whenever SCK is high. It goes low before the first command bit and returns high when the transfer ends.
- R5: A command count field of 1 to 5 sends that many command bytes. A value of 0, 6 or 7 sends all 5.
- R6: With data enable 1 and length L not 0, the command bytes are followed by L data bytes. With data enable 0, or with L equal to 0, the transfer ends after the command bytes.
- R7: With the read bit set, each data byte sends 0xFF on MOSI. The byte sampled from MISO goes onto the receive stream. `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low.
- R8: With the read bit clear, data bytes come from the transmit stream in order. A missing `tx_valid` pauses the transfer with SCK low.
- R9: The byte counter (address 4) counts completed data bytes. It is cleared at the start of each transfer, so a command-only transfer leaves it at 0.
- R10: The finish flag (address 2 bit 0, output `irq_fin`) is set when a transfer ends. The mid flag (bit 1, `irq_mid`) is set when the counter reaches 16*M with M not 0. Both flags stay set until software writes 1 to them.
- R11: While `busy` is high, writes to addresses 0, 1 and 3, to the mid count field and to addresses 5 to 9 are ignored. A control write while busy does not start a second transfer. Flag clears are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data at `cpu_addr` |
| busy | output | 1 | Transfer in progress |
| irq_fin | output | 1 | Finish flag |
| irq_mid | output | 1 | Mid-transfer flag |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Controller takes transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Sink takes received byte |
| rx_data | output | 8 | Received byte |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench builds the block with its default parameters: five command slots and a 7-bit divider. The five slots allow the command count clamp to be tested at 0 and at 7. The divider range allows both odd and even SCK periods (divide by 2, 3, 4 and 5) to be timed bit by bit. The 8-bit length allows transfers of 20 and 32 bytes. These reach the mid flag at 16 bytes and make it coincide with the finish flag at 32.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA} sfx_state_e;

  localparam logic [3:0] A_CLK  = 4'd0;
  localparam logic [3:0] A_CTRL = 4'd1;
  localparam logic [3:0] A_IRQ  = 4'd2;
  localparam logic [3:0] A_LEN  = 4'd3;
  localparam logic [3:0] A_CNT  = 4'd4;
  localparam logic [3:0] A_CMD0 = 4'd5;

  localparam logic [7:0] READ_FILL = 8'hFF;
endpackage

// File: rtl/sfx_regs.sv
module sfx_regs
  import sfx_pkg::*;
#(
  parameter int CMD_N = 5,
  parameter int DIV_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [3:0]             addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic                   busy,
  input  logic                   fin_set,
  input  logic                   mid_set,
  input  logic [7:0]             byte_cnt,
  output logic                   trig,
  output logic [DIV_W-1:0]       div,
  output logic [2:0]             ncmd_eff,
  output logic                   data_en,
  output logic                   rd_mode,
  output logic [7:0]             len,
  output logic [3:0]             mid_cnt,
  output logic [CMD_N-1:0][7:0]  cmd_bytes,
  output logic                   fin_flag,
  output logic                   mid_flag
);
  logic       en_q;
  logic [2:0] ncmd_q;
  logic       cfg_wr;
  logic       irq_wr;

  assign cfg_wr = wr && !busy;
  assign irq_wr = wr && (addr == A_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      div     <= '0;
      ncmd_q  <= '0;
      data_en <= 1'b0;
      rd_mode <= 1'b0;
      len     <= '0;
      mid_cnt <= '0;
    end else if (cfg_wr) begin
      case (addr)
        A_CLK: begin
          en_q <= wdata[7];
          div  <= wdata[DIV_W-1:0];
        end
        A_CTRL: begin
          data_en <= wdata[4];
          rd_mode <= wdata[3];
          ncmd_q  <= wdata[2:0];
        end
        A_LEN: len <= wdata;
        A_IRQ: mid_cnt <= wdata[7:4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_bytes <= '0;
    end else if (cfg_wr) begin
      for (int i = 0; i < CMD_N; i++) begin
        if (addr == A_CMD0 + 4'(i)) cmd_bytes[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_flag <= 1'b0;
      mid_flag <= 1'b0;
    end else begin
      fin_flag <= fin_set | (fin_flag & ~(irq_wr & wdata[0]));
      mid_flag <= mid_set | (mid_flag & ~(irq_wr & wdata[1]));
    end
  end

  assign trig     = cfg_wr && (addr == A_CTRL) && en_q && (div != '0);
  assign ncmd_eff = (ncmd_q == 3'd0 || ncmd_q > 3'(CMD_N)) ? 3'(CMD_N) : ncmd_q;

  always_comb begin
    rdata = 8'h00;
    case (addr)
      A_CLK: begin
        rdata    = 8'(div);
        rdata[7] = en_q;
      end
      A_CTRL: rdata = {3'b000, data_en, rd_mode, ncmd_q};
      A_IRQ:  rdata = {mid_cnt, 2'b00, mid_flag, fin_flag};
      A_LEN:  rdata = len;
      A_CNT:  rdata = byte_cnt;
      default: begin
        for (int i = 0; i < CMD_N; i++) begin
          if (addr == A_CMD0 + 4'(i)) rdata = cmd_bytes[i];
        end
      end
    endcase
  end

  // R11: the length register does not move while a transfer runs
  a_r11_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(len));

  // R10: the finish flag holds until it is cleared by software
  a_r10_fin_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fin_flag && !(irq_wr && wdata[0]) |=> fin_flag);
endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic [2:0]       bitn;
  logic [7:0]       txsr;

  assign half = div >> 1;
  assign sck  = active && (cnt > half);
  assign mosi = txsr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      txsr    <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cnt    <= '0;
          bitn   <= '0;
          txsr   <= tx_byte;
        end
      end else begin
        if (cnt == half) rx_byte <= {rx_byte[6:0], miso};
        if (cnt == div) begin
          cnt  <= '0;
          txsr <= {txsr[6:0], 1'b0};
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: MOSI holds while SCK stays high
  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck && $past(sck) |-> $stable(mosi));
endmodule

// File: rtl/sfx_ctrl.sv
module sfx_ctrl
  import sfx_pkg::*;
#(
  parameter int CMD_N = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig,
  input  logic [2:0]            ncmd_eff,
  input  logic                  data_en,
  input  logic                  rd_mode,
  input  logic [7:0]            len,
  input  logic [3:0]            mid_cnt,
  input  logic [CMD_N-1:0][7:0] cmd_bytes,
  input  logic                  tx_valid,
  input  logic [7:0]            tx_data,
  output logic                  tx_ready,
  output logic                  rx_valid,
  output logic [7:0]            rx_data,
  input  logic                  rx_ready,
  output logic                  sh_start,
  output logic [7:0]            sh_byte,
  input  logic                  sh_done,
  input  logic [7:0]            sh_rx,
  output logic                  busy,
  output logic                  cs_n,
  output logic [7:0]            byte_cnt,
  output logic                  fin_set,
  output logic                  mid_set
);
  sfx_state_e state;
  logic       pend;
  logic [2:0] idx;
  logic [7:0] cnt_nx;
  logic       last_cmd;

  assign busy     = (state != ST_IDLE);
  assign tx_ready = (state == ST_DATA) && !rd_mode && !pend;
  assign cnt_nx   = byte_cnt + 8'd1;
  assign last_cmd = (idx == ncmd_eff - 3'd1);

  always_comb begin
    sh_start = 1'b0;
    sh_byte  = READ_FILL;
    case (state)
      ST_CMD: begin
        sh_start = !pend;
        sh_byte  = cmd_bytes[idx];
      end
      ST_DATA: begin
        if (rd_mode) begin
          sh_start = !pend && !rx_valid;
        end else begin
          sh_start = tx_ready && tx_valid;
          sh_byte  = tx_data;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pend     <= 1'b0;
      idx      <= '0;
      byte_cnt <= '0;
      cs_n     <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      fin_set  <= 1'b0;
      mid_set  <= 1'b0;
    end else begin
      fin_set <= 1'b0;
      mid_set <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (sh_start) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (trig) begin
            state    <= ST_CMD;
            cs_n     <= 1'b0;
            idx      <= '0;
            byte_cnt <= '0;
            pend     <= 1'b0;
          end
        end
        ST_CMD: begin
          if (sh_done) begin
            pend <= 1'b0;
            idx  <= idx + 3'd1;
            if (last_cmd) begin
              if (data_en && len != 8'd0) begin
                state <= ST_DATA;
              end else begin
                state   <= ST_IDLE;
                cs_n    <= 1'b1;
                fin_set <= 1'b1;
              end
            end
          end
        end
        ST_DATA: begin
          if (sh_done) begin
            pend     <= 1'b0;
            byte_cnt <= cnt_nx;
            if (rd_mode) begin
              rx_valid <= 1'b1;
              rx_data  <= sh_rx;
            end
            if (mid_cnt != 4'd0 && cnt_nx == {mid_cnt, 4'b0000}) mid_set <= 1'b1;
            if (cnt_nx == len) begin
              state   <= ST_IDLE;
              cs_n    <= 1'b1;
              fin_set <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a pending received byte is held unchanged
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R9: the data phase never runs past the programmed length
  a_r9_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (byte_cnt < len));
endmodule

// File: rtl/sflash_xfer_ctrl.sv
module sflash_xfer_ctrl
  import sfx_pkg::*;
#(
  parameter int CMD_N = 5,
  parameter int DIV_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic [3:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       busy,
  output logic       irq_fin,
  output logic       irq_mid,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  logic                  trig;
  logic [DIV_W-1:0]      div;
  logic [2:0]            ncmd_eff;
  logic                  data_en;
  logic                  rd_mode;
  logic [7:0]            len;
  logic [3:0]            mid_cnt;
  logic [CMD_N-1:0][7:0] cmd_bytes;
  logic                  fin_set;
  logic                  mid_set;
  logic [7:0]            byte_cnt;
  logic                  sh_start;
  logic [7:0]            sh_byte;
  logic                  sh_done;
  logic [7:0]            sh_rx;

  sfx_regs #(.CMD_N(CMD_N), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
    .rdata(cpu_rdata), .busy(busy), .fin_set(fin_set), .mid_set(mid_set),
    .byte_cnt(byte_cnt), .trig(trig), .div(div), .ncmd_eff(ncmd_eff),
    .data_en(data_en), .rd_mode(rd_mode), .len(len), .mid_cnt(mid_cnt),
    .cmd_bytes(cmd_bytes), .fin_flag(irq_fin), .mid_flag(irq_mid)
  );

  sfx_ctrl #(.CMD_N(CMD_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ncmd_eff(ncmd_eff),
    .data_en(data_en), .rd_mode(rd_mode), .len(len), .mid_cnt(mid_cnt),
    .cmd_bytes(cmd_bytes), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .sh_start(sh_start), .sh_byte(sh_byte),
    .sh_done(sh_done), .sh_rx(sh_rx), .busy(busy), .cs_n(spi_cs_n),
    .byte_cnt(byte_cnt), .fin_set(fin_set), .mid_set(mid_set)
  );

  sfx_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .div(div), .start(sh_start), .tx_byte(sh_byte),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done),
    .rx_byte(sh_rx)
  );

  // R4: no SCK pulse outside an asserted chip select
  a_r4_cs_covers_sck: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);
endmodule

// File: tb/tb_sflash_xfer_ctrl.sv
module tb_sflash_xfer_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       busy, irq_fin, irq_mid;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       spi_sck, spi_mosi, spi_cs_n;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int tick = 0;
  int wd = 0;
  bit finished = 0;
  int cur_div = 1;

  logic [7:0] cmd_v [5] = '{8'h9F, 8'h03, 8'h12, 8'h34, 8'h56};
  logic [7:0] exp_mosi [$];
  logic [7:0] miso_q [$];
  logic [7:0] exp_rx [$];
  logic [7:0] tx_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  sflash_xfer_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy),
    .irq_fin(irq_fin), .irq_mid(irq_mid), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // behavioural flash model: collects MOSI bytes, drives MISO, times SCK
  logic       psck = 1'b0;
  bit         loaded = 0;
  int         nbits = 0;
  int         since = 0;
  int         bi = 7;
  logic [7:0] cur = '0;
  logic [7:0] msr = '0;

  function automatic logic [7:0] next_miso();
    if (miso_q.size() > 0) return miso_q.pop_front();
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sck && spi_cs_n) chk(0, "R4", "sck high with cs released", 1, 0);
      if (spi_cs_n) begin
        loaded = 0;
        nbits = 0;
      end else if (!loaded) begin
        cur = next_miso();
        bi = 7;
        spi_miso = cur[7];
        loaded = 1;
      end
      since++;
      if (spi_sck && !psck) begin
        if (nbits % 8 != 0) chk(since == cur_div + 1, "R3", "sck period", since, cur_div + 1);
        since = 0;
        msr = {msr[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0) begin
          if (exp_mosi.size() == 0) chk(0, "R2", "unexpected mosi byte", msr, 0);
          else begin
            logic [7:0] e;
            e = exp_mosi.pop_front();
            chk(msr == e, "R2", "mosi byte", msr, e);
          end
        end
      end
      if (!spi_sck && psck) begin
        chk(since == cur_div - cur_div / 2, "R3", "sck high time", since, cur_div - cur_div / 2);
        if (nbits % 8 == 0) begin
          cur = next_miso();
          bi = 7;
        end else bi--;
        spi_miso = cur[bi];
      end
      psck = spi_sck;
    end
  end

  // transmit stream source with bubbles
  bit tx_fire = 0;
  always @(negedge clk) begin
    if (tx_fire) begin
      void'(tx_q.pop_front());
      tx_valid = 1'b0;
    end
    if (!tx_valid && tx_q.size() > 0 && (tick % 4 != 1)) begin
      tx_valid = 1'b1;
      tx_data = tx_q[0];
    end
    #1 tx_fire = tx_valid && tx_ready;
  end

  // receive stream sink with stalls
  bit         prv_v = 0, prv_r = 0;
  logic [7:0] prv_d = '0;
  always @(negedge clk) begin
    rx_ready = (tick % 3 != 0);
    #1;
    if (prv_v && !prv_r)
      chk(rx_valid && rx_data == prv_d, "R7", "rx held under stall", rx_data, prv_d);
    if (rx_valid && rx_ready) begin
      if (exp_rx.size() == 0) chk(0, "R7", "unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, "R7", "rx byte", rx_data, e);
      end
    end
    prv_v = rx_valid;
    prv_r = rx_ready;
    prv_d = rx_data;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_wdata = d;
    cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    cpu_addr = a;
    #1 v = cpu_rdata;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, req, "transfer ended", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] ctrlv, input int nlen, input int neff,
                      input logic [7:0] base, input string req);
    logic [7:0] v;
    bit de, rdm;
    int ndata;
    de = ctrlv[4];
    rdm = ctrlv[3];
    ndata = (de && nlen > 0) ? nlen : 0;
    for (int i = 0; i < neff; i++) begin
      exp_mosi.push_back(cmd_v[i]);
      miso_q.push_back(8'h3C ^ 8'(i));
    end
    for (int i = 0; i < ndata; i++) begin
      if (rdm) begin
        exp_mosi.push_back(8'hFF);
        miso_q.push_back(base + 8'(i * 8'h11));
        exp_rx.push_back(base + 8'(i * 8'h11));
      end else begin
        tx_q.push_back(base + 8'(i * 7));
        exp_mosi.push_back(base + 8'(i * 7));
      end
    end
    wr(4'd3, 8'(nlen));
    wr(4'd1, ctrlv);
    wait_idle(req);
    chk(exp_mosi.size() == 0, req, "mosi bytes left", exp_mosi.size(), 0);
    chk(exp_rx.size() == 0, req, "rx bytes left", exp_rx.size(), 0);
    chk(spi_cs_n == 1'b1, "R4", "cs released at end", spi_cs_n, 1);
    rd(4'd4, v);
    chk(v == 8'(ndata), "R9", "byte counter", v, ndata);
    chk(irq_fin == 1'b1, "R10", "finish flag", irq_fin, 1);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "sck", spi_sck, 0);
    chk(!busy && !irq_fin && !irq_mid, "R1", "busy/irqs", {busy, irq_fin, irq_mid}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk(v == 8'h00, "R1", "register after reset", v, 0);
    end
    for (int i = 0; i < 5; i++) wr(4'(5 + i), cmd_v[i]);

    // R2: no start when disabled or with a zero divider
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h03);
    repeat (4) @(negedge clk);
    chk(!busy && spi_cs_n, "R2", "no start with enable clear", busy, 0);
    rd(4'd1, v);
    chk(v == 8'h03, "R2", "control stored", v, 8'h03);
    wr(4'd0, 8'h80);
    wr(4'd1, 8'h03);
    repeat (4) @(negedge clk);
    chk(!busy && spi_cs_n, "R2", "no start with zero divider", busy, 0);

    // R2 R6: command only, three bytes
    cur_div = 1;
    wr(4'd0, 8'h81);
    xfer(8'h03, 0, 3, 8'h00, "R6");
    chk(irq_mid == 1'b0, "R10", "mid flag idle", irq_mid, 0);
    wr(4'd2, 8'h01);
    @(negedge clk);
    chk(irq_fin == 1'b0, "R10", "finish cleared", irq_fin, 0);

    // R5: command count clamp
    cur_div = 4;
    wr(4'd0, 8'h84);
    xfer(8'h00, 0, 5, 8'h00, "R5");
    wr(4'd2, 8'h01);
    cur_div = 3;
    wr(4'd0, 8'h83);
    xfer(8'h07, 0, 5, 8'h00, "R5");
    wr(4'd2, 8'h01);

    // R8 R10: 20-byte write with bubbles, mid count 1
    cur_div = 2;
    wr(4'd0, 8'h82);
    wr(4'd2, 8'h10);
    xfer(8'h11, 20, 1, 8'h21, "R8");
    chk(irq_mid == 1'b1, "R10", "mid flag at 16", irq_mid, 1);
    wr(4'd2, 8'h11);
    @(negedge clk);
    chk(!irq_fin && irq_mid, "R10", "clear finish only", {irq_fin, irq_mid}, 1);
    wr(4'd2, 8'h12);
    @(negedge clk);
    chk(!irq_mid, "R10", "clear mid", irq_mid, 0);

    // R10: mid count 2 never reached in 20 bytes
    wr(4'd2, 8'h20);
    xfer(8'h11, 20, 1, 8'h40, "R8");
    chk(irq_mid == 1'b0, "R10", "mid not reached", irq_mid, 0);
    wr(4'd2, 8'h21);

    // R7: read six bytes with sink stalls
    cur_div = 1;
    wr(4'd0, 8'h81);
    xfer(8'h1A, 6, 2, 8'hA0, "R7");
    wr(4'd2, 8'h21);

    // R6 R9: data enable with zero length, counter cleared
    xfer(8'h11, 0, 1, 8'h00, "R6");
    wr(4'd2, 8'h21);

    // R10: mid and finish together at 32
    xfer(8'h11, 32, 1, 8'h05, "R10");
    chk(irq_mid == 1'b1, "R10", "mid at 32", irq_mid, 1);
    wr(4'd2, 8'h23);

    // R11: writes while busy ignored
    cur_div = 3;
    wr(4'd0, 8'h83);
    for (int i = 0; i < 4; i++) begin
      tx_q.push_back(8'hC0 + 8'(i));
      exp_mosi.push_back(8'hC0 + 8'(i));
    end
    exp_mosi.push_front(cmd_v[0]);
    miso_q.push_back(8'h00);
    wr(4'd3, 8'd4);
    wr(4'd1, 8'h11);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R11", "transfer running", busy, 1);
    wr(4'd5, 8'hEE);
    wr(4'd3, 8'd9);
    wr(4'd0, 8'h81);
    wr(4'd1, 8'h19);
    wait_idle("R11");
    chk(exp_mosi.size() == 0, "R11", "no extra bytes", exp_mosi.size(), 0);
    rd(4'd5, v);
    chk(v == cmd_v[0], "R11", "command byte kept", v, cmd_v[0]);
    rd(4'd3, v);
    chk(v == 8'd4, "R11", "length kept", v, 4);
    rd(4'd0, v);
    chk(v == 8'h83, "R11", "clock reg kept", v, 8'h83);
    rd(4'd4, v);
    chk(v == 8'd4, "R9", "counter after guarded run", v, 4);

    finished = 1;
    summary();
    $finish;
  end
endmodule